// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block is the control engine that takes a delta-sigma converter through its self-calibration. When a calibration command arrives it steers the modulator input to an internal zero and uses the filter result at the end of that phase as the offset correction. It then steers the input across the internal reference and derives the gain correction from the reference result minus the new offset. Finally it reconnects the signal input and lets the decimation filter refill before it publishes data again. A second command runs a full-scale calibration on whatever the signal input carries and skips the refill, because the filter already holds settled data.

In normal operation every conversion period delivers one raw filter word. The block subtracts the offset register, multiplies by the gain register (unsigned, 1.0 equals 2^FRAC), saturates to the signed output width, updates the data register and then lowers the active-low data-ready strobe. Register writes from the host share the two correction registers. A write that lands while a result is being formed is parked and applied once that result is finished, so that one conversion never mixes old and new coefficients.

Top module: `adc_selfcal_seq`

## Requirements
- R1: After reset, drdy_n is 1, mux_sel is 0 (signal input), dout is 0, offset_q is 0 and gain_q is 0x400000 (unity).
- R2: In normal operation a period_tick raises drdy_n at the sampling edge, dout takes the corrected value one edge later, and drdy_n falls on the edge after that.
- R3: The corrected value is ((raw − offset_q) × gain_q) >> 22 in two's complement, saturated to 0x7FFFFF above and 0x800000 below.
- R4: A self_cal pulse sets mux_sel to 1 (internal zero) for 3 periods, or 4 when slave_mode is 1; the raw word of the last of those periods is written to offset_q and mux_sel then becomes 2 (reference).
- R5: The reference phase lasts 3 periods; at its last period gain_q becomes 0x400000 × 2^22 / (raw − offset_q), forced to 0xFFFFFF when that quotient exceeds 24 bits or the divisor is zero or negative.
- R6: From the edge after a calibration command until data is published again, drdy_n stays 1 and dout does not change; after the reference phase mux_sel is 0 for 3 refill periods, and only the fourth period after the reference phase publishes data.
- R7: A sys_cal pulse keeps mux_sel at 0, runs the 3-period gain phase on the signal input with no refill, and the very next period publishes data.
- R8: A host write (wr_sel 0 selects offset_q, 1 selects gain_q) that arrives on a normal-mode tick or the cycle after it is held off, takes effect two edges later, and the result under way uses the old coefficient.
- R9: self_cal and sys_cal pulses that arrive while a sequence is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| self_cal | input | 1 | Start offset plus reference calibration |
| sys_cal | input | 1 | Start full-scale calibration on the signal input |
| slave_mode | input | 1 | Selects the four-period offset phase |
| period_tick | input | 1 | One-cycle pulse per conversion period, raw_data valid |
| raw_data | input | 24 | Raw filter result, two's complement |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0 offset register, 1 gain register |
| wr_data | input | 24 | Host write value |
| mux_sel | output | 2 | 0 signal input, 1 internal zero, 2 reference |
| drdy_n | output | 1 | Active-low data-ready |
| dout | output | 24 | Corrected data register |
| offset_q | output | 24 | Offset correction register |
| gain_q | output | 24 | Gain correction register |

## Verification
A phase counter that is off by one shows at once on mux_sel at the tick where the phase should have ended, and the wrong raw word then lands in offset_q or gain_q within the same period. A divider or multiplier fault shows only on the first published word after calibration, some periods later, as a dout value that differs from the bench's own arithmetic. A lost hold-off or suppression shows within two edges as a changed offset_q or a low drdy_n while the mux is away from the signal input.

// File: rtl/adc_selfcal_pkg.sv
// Shared encodings for the self-calibration sequencer.
// Assumes: the mux code values are decoded by the analog switch block.
package adc_selfcal_pkg;
    typedef enum logic [1:0] {
        MUX_INPUT = 2'd0,
        MUX_ZERO  = 2'd1,
        MUX_REF   = 2'd2
    } mux_e;

    typedef enum logic [1:0] {
        ST_NORM = 2'd0,
        ST_OFS  = 2'd1,
        ST_GAIN = 2'd2,
        ST_FILL = 2'd3
    } seq_e;
endpackage

// File: rtl/cal_seq_fsm.sv
// Phase sequencer: counts conversion periods through offset, gain and
// refill phases and issues the capture strobes at each phase's last period.
// Assumes: commands are single-cycle pulses, ticks are single-cycle pulses.
module cal_seq_fsm
    import adc_selfcal_pkg::*;
#(
    parameter int OFS_N       = 3,
    parameter int OFS_N_SLAVE = 4,
    parameter int GAIN_N      = 3,
    parameter int FILL_N      = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic self_cal,
    input  logic sys_cal,
    input  logic slave_mode,
    input  logic period_tick,
    output seq_e state,
    output mux_e mux,
    output logic ofs_capture,
    output logic gain_capture
);
    localparam int MAXN = (OFS_N_SLAVE > OFS_N) ? OFS_N_SLAVE : OFS_N;
    localparam int MAXA = (GAIN_N > FILL_N) ? GAIN_N : FILL_N;
    localparam int CW   = $clog2(((MAXN > MAXA) ? MAXN : MAXA) + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] ofs_last;
    logic          sys_q;
    logic          last_gain;
    logic          last_fill;

    assign last_gain = (cnt == CW'(GAIN_N - 1));
    assign last_fill = (cnt == CW'(FILL_N - 1));

    // Phase state and period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_NORM;
            cnt      <= '0;
            ofs_last <= CW'(OFS_N - 1);
            sys_q    <= 1'b0;
        end else begin
            case (state)
                ST_NORM: begin
                    cnt <= '0;
                    if (self_cal) begin
                        state    <= ST_OFS;
                        sys_q    <= 1'b0;
                        ofs_last <= slave_mode ? CW'(OFS_N_SLAVE - 1) : CW'(OFS_N - 1);
                    end else if (sys_cal) begin
                        state <= ST_GAIN;
                        sys_q <= 1'b1;
                    end
                end
                ST_OFS: if (period_tick) begin
                    if (cnt == ofs_last) begin
                        state <= ST_GAIN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAIN: if (period_tick) begin
                    if (last_gain) begin
                        state <= sys_q ? ST_NORM : ST_FILL;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: if (period_tick) begin
                    if (last_fill) begin
                        state <= ST_NORM;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Capture strobes at the last period of each measuring phase.
    always_comb begin
        ofs_capture  = (state == ST_OFS)  && period_tick && (cnt == ofs_last);
        gain_capture = (state == ST_GAIN) && period_tick && last_gain;
    end

    // Input steering decoded from the phase.
    always_comb begin
        case (state)
            ST_OFS:  mux = MUX_ZERO;
            ST_GAIN: mux = sys_q ? MUX_INPUT : MUX_REF;
            default: mux = MUX_INPUT;
        endcase
    end
endmodule

// File: rtl/cal_gain_div.sv
// Restoring divider producing the gain coefficient NOM_FS*2^FRAC/meas.
// Assumes: the next start arrives more than DW+FRAC cycles later.
module cal_gain_div #(
    parameter int DW     = 24,
    parameter int FRAC   = 22,
    parameter int NOM_FS = 4194304
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic signed [DW:0] meas,
    output logic              done,
    output logic [DW-1:0]     quot
);
    localparam int NW = DW + FRAC;
    localparam int SW = $clog2(NW);
    localparam logic [NW-1:0] DIVIDEND = NW'(NOM_FS) << FRAC;

    logic [NW-1:0] dvd;
    logic [NW-1:0] q;
    logic [NW-1:0] q_nx;
    logic [DW-1:0] rem;
    logic [DW-1:0] rem_nx;
    logic [DW-1:0] dsr;
    logic [DW:0]   rem_sh;
    logic [SW-1:0] step;
    logic          busy;
    logic          bad;
    logic          ge;

    // One quotient bit per cycle.
    always_comb begin
        rem_sh = {rem, dvd[NW-1]};
        ge     = (rem_sh >= {1'b0, dsr});
        rem_nx = ge ? DW'(rem_sh - {1'b0, dsr}) : rem_sh[DW-1:0];
        q_nx   = {q[NW-2:0], ge};
    end

    // Iteration control and saturated result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            bad  <= 1'b0;
            done <= 1'b0;
            dvd  <= '0;
            q    <= '0;
            rem  <= '0;
            dsr  <= '0;
            step <= '0;
            quot <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                bad  <= (meas <= 0);
                dsr  <= meas[DW-1:0];
                dvd  <= DIVIDEND;
                q    <= '0;
                rem  <= '0;
                step <= '0;
            end else if (busy) begin
                dvd  <= dvd << 1;
                q    <= q_nx;
                rem  <= rem_nx;
                step <= step + 1'b1;
                if (step == SW'(NW - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    quot <= (bad || (|q_nx[NW-1:DW])) ? '1 : q_nx[DW-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/cal_corr_pipe.sv
// Correction pipeline: subtract offset, scale by gain, saturate, publish
// to the data register, then lower data-ready one edge later.
// Assumes: loads are at least three cycles apart.
module cal_corr_pipe #(
    parameter int DW   = 24,
    parameter int FRAC = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          period_tick,
    input  logic          hold,
    input  logic [DW-1:0] raw,
    input  logic [DW-1:0] offset,
    input  logic [DW-1:0] gain,
    output logic [DW-1:0] dout,
    output logic          drdy_n,
    output logic          busy
);
    localparam int PW = 2 * DW + 2;

    logic signed [DW:0]   diff;
    logic                 s1_v;
    logic                 pub_v;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] sh;
    logic                 fits;
    logic [DW-1:0]        sat;

    // Scale and clip the stage-one difference.
    always_comb begin
        prod = diff * $signed({1'b0, gain});
        sh   = prod >>> FRAC;
        fits = (&sh[PW-1:DW-1]) | ~(|sh[PW-1:DW-1]);
        if (fits)
            sat = sh[DW-1:0];
        else
            sat = sh[PW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    end

    assign busy = load | s1_v;

    // Stage one: offset subtraction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff <= '0;
            s1_v <= 1'b0;
        end else begin
            s1_v <= load;
            if (load)
                diff <= $signed({raw[DW-1], raw}) - $signed({offset[DW-1], offset});
        end
    end

    // Stage two: data register update; stage three: data-ready strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout   <= '0;
            pub_v  <= 1'b0;
            drdy_n <= 1'b1;
        end else begin
            pub_v <= s1_v;
            if (s1_v)
                dout <= sat;
            if (period_tick || hold)
                drdy_n <= 1'b1;
            else if (pub_v)
                drdy_n <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_selfcal_seq.sv
// Top of the self-calibration sequencer: owns the offset and gain
// registers, arbitrates host writes against calibration captures and the
// running correction, and ties the phase FSM, divider and pipeline.
// Assumes: period_tick pulses are more than DW+FRAC+2 cycles apart.
module adc_selfcal_seq
    import adc_selfcal_pkg::*;
#(
    parameter int DW          = 24,
    parameter int FRAC        = 22,
    parameter int NOM_FS      = 4194304,
    parameter int OFS_N       = 3,
    parameter int OFS_N_SLAVE = 4,
    parameter int GAIN_N      = 3,
    parameter int FILL_N      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          self_cal,
    input  logic          sys_cal,
    input  logic          slave_mode,
    input  logic          period_tick,
    input  logic [DW-1:0] raw_data,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [1:0]    mux_sel,
    output logic          drdy_n,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] offset_q,
    output logic [DW-1:0] gain_q
);
    localparam logic [DW-1:0] UNITY = DW'(1) << FRAC;

    seq_e               state;
    mux_e               mux;
    logic               ofs_cap;
    logic               gain_cap;
    logic               div_done;
    logic [DW-1:0]      quot;
    logic signed [DW:0] meas;
    logic               load;
    logic               upd_busy;
    logic               pend_v;
    logic               pend_sel;
    logic [DW-1:0]      pend_data;

    assign mux_sel = mux;
    assign load    = period_tick && (state == ST_NORM);
    assign meas    = $signed({raw_data[DW-1], raw_data}) - $signed({offset_q[DW-1], offset_q});

    cal_seq_fsm #(
        .OFS_N(OFS_N), .OFS_N_SLAVE(OFS_N_SLAVE), .GAIN_N(GAIN_N), .FILL_N(FILL_N)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .self_cal(self_cal), .sys_cal(sys_cal),
        .slave_mode(slave_mode), .period_tick(period_tick), .state(state),
        .mux(mux), .ofs_capture(ofs_cap), .gain_capture(gain_cap)
    );

    cal_gain_div #(.DW(DW), .FRAC(FRAC), .NOM_FS(NOM_FS)) u_div (
        .clk(clk), .rst_n(rst_n), .start(gain_cap), .meas(meas),
        .done(div_done), .quot(quot)
    );

    cal_corr_pipe #(.DW(DW), .FRAC(FRAC)) u_pipe (
        .clk(clk), .rst_n(rst_n), .load(load), .period_tick(period_tick),
        .hold(state != ST_NORM), .raw(raw_data), .offset(offset_q),
        .gain(gain_q), .dout(dout), .drdy_n(drdy_n), .busy(upd_busy)
    );

    // Coefficient registers: host writes (deferred while busy), then captures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q  <= '0;
            gain_q    <= UNITY;
            pend_v    <= 1'b0;
            pend_sel  <= 1'b0;
            pend_data <= '0;
        end else begin
            if (upd_busy) begin
                if (wr_en) begin
                    pend_v    <= 1'b1;
                    pend_sel  <= wr_sel;
                    pend_data <= wr_data;
                end
            end else begin
                pend_v <= 1'b0;
                if (wr_en) begin
                    if (wr_sel) gain_q <= wr_data;
                    else        offset_q <= wr_data;
                end else if (pend_v) begin
                    if (pend_sel) gain_q <= pend_data;
                    else          offset_q <= pend_data;
                end
            end
            if (ofs_cap)
                offset_q <= raw_data;
            if (div_done)
                gain_q <= quot;
        end
    end
endmodule

// File: rtl/adc_selfcal_chk.sv
// Property checker for the self-calibration sequencer, bound to the top.
module adc_selfcal_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          period_tick,
    input logic [1:0]    mux_sel,
    input logic          drdy_n,
    input logic          wr_en,
    input logic          wr_sel,
    input logic          upd_busy,
    input logic [DW-1:0] offset_q
);
    assert_mux_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mux_sel != 2'd3);

    assert_tick_raises_drdy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        period_tick |=> drdy_n);

    assert_no_drdy_off_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel != 2'd0) |=> drdy_n);

    assert_write_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && upd_busy) |=> $stable(offset_q));
endmodule

bind adc_selfcal_seq adc_selfcal_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .mux_sel(mux_sel),
    .drdy_n(drdy_n), .wr_en(wr_en), .wr_sel(wr_sel), .upd_busy(upd_busy),
    .offset_q(offset_q)
);

// File: tb/adc_selfcal_seq_bench.sv
module adc_selfcal_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        self_cal = 1'b0;
    logic        sys_cal = 1'b0;
    logic        slave_mode = 1'b0;
    logic        period_tick = 1'b0;
    logic [23:0] raw_data = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [23:0] wr_data = '0;
    logic [1:0]  mux_sel;
    logic        drdy_n;
    logic [23:0] dout;
    logic [23:0] offset_q;
    logic [23:0] gain_q;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_selfcal_seq u_adc_selfcal_seq (
        .clk(clk), .rst_n(rst_n), .self_cal(self_cal), .sys_cal(sys_cal),
        .slave_mode(slave_mode), .period_tick(period_tick), .raw_data(raw_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .mux_sel(mux_sel),
        .drdy_n(drdy_n), .dout(dout), .offset_q(offset_q), .gain_q(gain_q)
    );

    function automatic logic [23:0] exp_corr(logic [23:0] raw, logic [23:0] ofs, logic [23:0] g);
        longint d, p, s;
        d = longint'($signed(raw)) - longint'($signed(ofs));
        p = d * longint'({40'd0, g});
        s = p >>> 22;
        if (s > 64'sd8388607)  s = 64'sd8388607;
        if (s < -64'sd8388608) s = -64'sd8388608;
        return s[23:0];
    endfunction

    function automatic logic [23:0] exp_gain(logic [23:0] raw, logic [23:0] ofs);
        longint m, q;
        m = longint'($signed(raw)) - longint'($signed(ofs));
        if (m <= 0) return 24'hFFFFFF;
        q = (longint'(4194304) <<< 22) / m;
        if (q > 64'sd16777215) return 24'hFFFFFF;
        return q[23:0];
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One conversion period: tick for one cycle, then wait out the period.
    task automatic tick(input logic [23:0] raw);
        @(negedge clk);
        period_tick = 1'b1;
        raw_data    = raw;
        @(negedge clk);
        period_tick = 1'b0;
        repeat (GAP - 2) @(negedge clk);
    endtask

    task automatic host_write(input logic sel, input logic [23:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 drdy_n", drdy_n, 1);
        chk("R1 mux_sel", mux_sel, 0);
        chk("R1 dout", dout, 0);
        chk("R1 offset_q", offset_q, 0);
        chk("R1 gain_q", gain_q, 24'h400000);
    endtask

    // Cycle-exact view of one normal conversion.
    task automatic t_normal(input logic [23:0] raw);
        logic [23:0] e;
        e = exp_corr(raw, offset_q, gain_q);
        @(negedge clk);
        period_tick = 1'b1; raw_data = raw;
        @(negedge clk);
        period_tick = 1'b0;
        chk("R2 drdy_n high after tick edge", drdy_n, 1);
        @(negedge clk);
        chk("R2 dout one edge later", dout, e);
        chk("R2 drdy_n still high", drdy_n, 1);
        @(negedge clk);
        chk("R2 drdy_n falls", drdy_n, 0);
        repeat (GAP - 4) @(negedge clk);
    endtask

    task automatic t_holdoff();
        logic [23:0] old_ofs;
        old_ofs = offset_q;
        @(negedge clk);
        period_tick = 1'b1; raw_data = 24'd1034;
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 24'd34;
        @(negedge clk);
        period_tick = 1'b0; wr_en = 1'b0;
        chk("R8 offset held during update", offset_q, old_ofs);
        @(negedge clk);
        @(negedge clk);
        chk("R8 write applied after update", offset_q, 24'd34);
        chk("R8 result used old offset", dout, exp_corr(24'd1034, old_ofs, gain_q));
        repeat (GAP - 4) @(negedge clk);
        tick(24'd1034);
        chk("R8 next result uses new offset", dout, exp_corr(24'd1034, 24'd34, gain_q));
    endtask

    task automatic t_selfcal(input logic slave, input logic [23:0] ofs_raw,
                             input logic [23:0] ref_raw, input logic [23:0] data_raw);
        logic [23:0] d_before, g_exp;
        slave_mode = slave;
        d_before = dout;
        @(negedge clk);
        self_cal = 1'b1;
        @(negedge clk);
        self_cal = 1'b0;
        chk("R4 mux to zero", mux_sel, 1);
        @(negedge clk);
        chk("R6 drdy_n raised by command", drdy_n, 1);
        tick(24'd555);
        // stray commands during the sequence
        @(negedge clk); sys_cal = 1'b1; self_cal = 1'b1;
        @(negedge clk); sys_cal = 1'b0; self_cal = 1'b0;
        chk("R9 command ignored", mux_sel, 1);
        tick(24'd555);
        if (slave) begin
            tick(24'd555);
            chk("R4 slave offset phase longer", mux_sel, 1);
        end
        tick(ofs_raw);
        chk("R4 mux to reference", mux_sel, 2);
        chk("R4 offset captured", offset_q, ofs_raw);
        tick(24'd777);
        tick(24'd777);
        tick(ref_raw);
        g_exp = exp_gain(ref_raw, ofs_raw);
        chk("R5 gain computed", gain_q, g_exp);
        chk("R6 mux back to input", mux_sel, 0);
        for (int i = 0; i < 3; i++) begin
            tick(data_raw);
            chk("R6 drdy_n high in refill", drdy_n, 1);
            chk("R6 dout unchanged in refill", dout, d_before);
        end
        tick(data_raw);
        chk("R6 data published after refill", drdy_n, 0);
        chk("R3 corrected value", dout, exp_corr(data_raw, ofs_raw, g_exp));
        slave_mode = 1'b0;
    endtask

    task automatic t_syscal();
        logic [23:0] g_exp, d_before;
        host_write(1'b0, 24'd0);
        host_write(1'b1, 24'h400000);
        d_before = dout;
        @(negedge clk);
        sys_cal = 1'b1;
        @(negedge clk);
        sys_cal = 1'b0;
        chk("R7 mux stays on input", mux_sel, 0);
        tick(24'h300000);
        tick(24'h300000);
        chk("R7 drdy_n high during gain phase", drdy_n, 1);
        tick(24'h300000);
        g_exp = exp_gain(24'h300000, 24'd0);
        chk("R7 gain from input", gain_q, g_exp);
        chk("R7 dout unchanged", dout, d_before);
        tick(24'h300000);
        chk("R7 data next period", drdy_n, 0);
        chk("R7 corrected value", dout, exp_corr(24'h300000, 24'd0, g_exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_normal(24'd1234);
        t_normal(-24'sd5000);
        t_holdoff();
        t_selfcal(1'b0, 24'd100, 24'h200064, 24'd1100);
        t_selfcal(1'b1, 24'd500, 24'd400, 24'h700000);
        tick(24'h900000);
        chk("R3 negative saturation", dout, 24'h800000);
        t_syscal();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule